// File: doc/BRIEF.md
# Prioritized Maskable Interrupt Controller

This block gathers a set of maskable request lines for a small processor core and picks, every cycle, the one source the core should take next. Each source owns a 3-bit level and a pending flag. A request pulse latches the pending flag. A global enable bit and a 3-bit processor threshold decide whether any latched request may be presented at all.

The winner's index and level appear on the output together with a valid strobe. They are computed combinationally from the stored state. When the core takes a vector, it returns that index on the acknowledge port, and only that source's pending flag drops.

Software programs the block through a narrow write-only port. At source addresses 0 to NUM_SRC-1, data bits [2:0] set the level, and data bit 3 written as 0 clears the pending flag. Address NUM_SRC holds the global enable in bit 0. Address NUM_SRC+1 holds the threshold in bits [2:0].

Top module: `mask_irq_ctrl`

## Requirements
- R1: After reset every level, pending flag, the global enable and the threshold are 0, and irqValid is low.
- R2: A source whose level is 000b is never presented, even with its pending flag set; levels 001b to 111b rank 1 to 7, with 7 the most urgent.
- R3: While the global enable (address NUM_SRC, bit 0) is 0, irqValid stays low whatever the pending flags are.
- R4: A one-cycle pulse on srcReq[i] sets pending flag i at the next clock edge, and the flag stays set after the pulse ends.
- R5: A source is eligible only when its level is strictly greater than the threshold (address NUM_SRC+1, bits [2:0]); threshold 000b admits level 1 and up, and threshold 111b blocks every source.
- R6: Among eligible sources, the highest level wins, and equal levels go to the lowest index; irqIdx and irqLevel then carry that source's index and level.
- R7: With ackEn high, the pending flag of source ackIdx is 0 after the next clock edge, and no other source's flag changes.
- R8: A write to source address i with data bit 3 equal to 0 clears pending flag i; with bit 3 equal to 1 the flag keeps its value.
- R9: When a request pulse on source i falls in the same cycle as a software clear or an acknowledge of source i, the flag ends set.
- R10: The levels, the pending flags, the global enable and the threshold are separate storage; a write to one leaves every other unchanged.
- R11: irqValid, irqIdx and irqLevel follow the stored state in the same cycle, with no added register stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| srcReq | input | NUM_SRC | Request pulses, one bit per source |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | ADDR_W | Register address: sources, then enable, then threshold |
| wrData | input | 8 | Write data |
| ackEn | input | 1 | Core has taken a vector |
| ackIdx | input | IDX_W | Index of the source taken |
| irqValid | output | 1 | A source is eligible |
| irqIdx | output | IDX_W | Index of the winning source |
| irqLevel | output | 3 | Level of the winning source |

## Verification
A request pulse can land on the same flag in the same cycle as a software clear or an acknowledge. Both cases are driven on purpose, and both are also reached by a long random phase that mixes pulses, writes and acknowledges. A behavioural model in the bench applies the rule that the set wins. The bench compares valid, index and level against this model after every clock edge, so a lost event shows up as a mismatch on the very next cycle.

// File: rtl/irq_pkg.sv
package irq_pkg;
  parameter int LVL_W = 3;
  parameter int DATA_W = 8;
  parameter int SEL_W = 8;
  parameter int PEND_BIT = 3;

  typedef struct packed {
    logic             srcWr;
    logic [SEL_W-1:0] srcSel;
    logic [LVL_W-1:0] lvlVal;
    logic             pendClr;
    logic             enWr;
    logic             enVal;
    logic             thrWr;
    logic [LVL_W-1:0] thrVal;
    logic             ackClr;
    logic [SEL_W-1:0] ackSel;
  } irqStrobe_t;
endpackage

// File: rtl/irq_ctrl_dec.sv
module irq_ctrl_dec
  import irq_pkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter int ADDR_W = $clog2(NUM_SRC + 2),
  parameter int IDX_W = $clog2(NUM_SRC)
) (
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              ackEn,
  input  logic [IDX_W-1:0]  ackIdx,
  output irqStrobe_t        stb
);
  localparam int EN_ADDR = NUM_SRC;
  localparam int THR_ADDR = NUM_SRC + 1;

  logic isSrc;

  always_comb begin
    isSrc = (32'(wrAddr) < NUM_SRC);
    stb = '0;
    stb.srcWr = wrEn && isSrc;
    stb.srcSel = SEL_W'(wrAddr);
    stb.lvlVal = wrData[LVL_W-1:0];
    stb.pendClr = ~wrData[PEND_BIT];
    stb.enWr = wrEn && (32'(wrAddr) == EN_ADDR);
    stb.enVal = wrData[0];
    stb.thrWr = wrEn && (32'(wrAddr) == THR_ADDR);
    stb.thrVal = wrData[LVL_W-1:0];
    stb.ackClr = ackEn;
    stb.ackSel = SEL_W'(ackIdx);
  end
endmodule

// File: rtl/irq_datapath.sv
module irq_datapath
  import irq_pkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter int IDX_W = $clog2(NUM_SRC)
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [NUM_SRC-1:0]              srcReq,
  input  irqStrobe_t                      stb,
  output logic [NUM_SRC-1:0]              pendQ,
  output logic [NUM_SRC-1:0][LVL_W-1:0]   levelQ,
  output logic                            gEnQ,
  output logic [LVL_W-1:0]                thrQ,
  output logic                            irqValid,
  output logic [IDX_W-1:0]                irqIdx,
  output logic [LVL_W-1:0]                irqLevel
);
  logic [NUM_SRC-1:0] eligible;
  logic [NUM_SRC-1:0] swClr;
  logic [NUM_SRC-1:0] ackHit;
  logic [NUM_SRC-1:0] lvlHit;

  for (genvar gi = 0; gi < NUM_SRC; gi++) begin : g_src
    assign lvlHit[gi] = stb.srcWr && (stb.srcSel == SEL_W'(gi));
    assign swClr[gi] = lvlHit[gi] && stb.pendClr;
    assign ackHit[gi] = stb.ackClr && (stb.ackSel == SEL_W'(gi));
    assign eligible[gi] = gEnQ && pendQ[gi] && (levelQ[gi] > thrQ);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pendQ <= '0;
      levelQ <= '0;
    end else begin
      for (int i = 0; i < NUM_SRC; i++) begin
        if (lvlHit[i]) levelQ[i] <= stb.lvlVal;
        if (srcReq[i]) pendQ[i] <= 1'b1;
        else if (swClr[i] || ackHit[i]) pendQ[i] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gEnQ <= 1'b0;
      thrQ <= '0;
    end else begin
      if (stb.enWr) gEnQ <= stb.enVal;
      if (stb.thrWr) thrQ <= stb.thrVal;
    end
  end

  always_comb begin
    irqValid = 1'b0;
    irqIdx = '0;
    irqLevel = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (eligible[i] && (!irqValid || levelQ[i] > irqLevel)) begin
        irqValid = 1'b1;
        irqIdx = IDX_W'(i);
        irqLevel = levelQ[i];
      end
    end
  end
endmodule

// File: rtl/mask_irq_ctrl.sv
module mask_irq_ctrl
  import irq_pkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter int IDX_W = $clog2(NUM_SRC),
  parameter int ADDR_W = $clog2(NUM_SRC + 2)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] srcReq,
  input  logic               wrEn,
  input  logic [ADDR_W-1:0]  wrAddr,
  input  logic [DATA_W-1:0]  wrData,
  input  logic               ackEn,
  input  logic [IDX_W-1:0]   ackIdx,
  output logic               irqValid,
  output logic [IDX_W-1:0]   irqIdx,
  output logic [LVL_W-1:0]   irqLevel
);
  irqStrobe_t stb;
  logic [NUM_SRC-1:0] pendQ;
  logic [NUM_SRC-1:0][LVL_W-1:0] levelQ;
  logic gEnQ;
  logic [LVL_W-1:0] thrQ;

  irq_ctrl_dec #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_dec (
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .ackEn(ackEn), .ackIdx(ackIdx), .stb(stb)
  );

  irq_datapath #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .srcReq(srcReq), .stb(stb),
    .pendQ(pendQ), .levelQ(levelQ), .gEnQ(gEnQ), .thrQ(thrQ),
    .irqValid(irqValid), .irqIdx(irqIdx), .irqLevel(irqLevel)
  );
endmodule

// File: rtl/mask_irq_ctrl_chk.sv
module mask_irq_ctrl_chk
  import irq_pkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter int IDX_W = $clog2(NUM_SRC)
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic [NUM_SRC-1:0]            srcReq,
  input logic                          ackEn,
  input logic [IDX_W-1:0]              ackIdx,
  input logic [NUM_SRC-1:0]            pendQ,
  input logic [NUM_SRC-1:0][LVL_W-1:0] levelQ,
  input logic                          gEnQ,
  input logic [LVL_W-1:0]              thrQ,
  input logic                          irqValid,
  input logic [IDX_W-1:0]              irqIdx,
  input logic [LVL_W-1:0]              irqLevel
);
  AST_LEVEL_NONZERO: assert property (@(posedge clk) disable iff (!rst_n) irqValid |-> irqLevel != '0); // R2
  AST_ENABLE_GATES: assert property (@(posedge clk) disable iff (!rst_n) irqValid |-> gEnQ); // R3
  AST_WIN_PENDING: assert property (@(posedge clk) disable iff (!rst_n) irqValid |-> pendQ[irqIdx]); // R4
  AST_ABOVE_THRESHOLD: assert property (@(posedge clk) disable iff (!rst_n) irqValid |-> irqLevel > thrQ); // R5
  AST_LEVEL_MATCH: assert property (@(posedge clk) disable iff (!rst_n) irqValid |-> irqLevel == levelQ[irqIdx]); // R6
  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) (ackEn && !srcReq[ackIdx]) |=> !pendQ[$past(ackIdx)]); // R7

  for (genvar gi = 0; gi < NUM_SRC; gi++) begin : g_chk
    AST_EVENT_SETS: assert property (@(posedge clk) disable iff (!rst_n) srcReq[gi] |=> pendQ[gi]); // R9
    AST_NO_SW_SET: assert property (@(posedge clk) disable iff (!rst_n) (!pendQ[gi] && !srcReq[gi]) |=> !pendQ[gi]); // R8
  end
endmodule

bind mask_irq_ctrl mask_irq_ctrl_chk #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .srcReq(srcReq), .ackEn(ackEn), .ackIdx(ackIdx),
  .pendQ(pendQ), .levelQ(levelQ), .gEnQ(gEnQ), .thrQ(thrQ),
  .irqValid(irqValid), .irqIdx(irqIdx), .irqLevel(irqLevel)
);

// File: tb/mask_irq_ctrl_tb.sv
module mask_irq_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NUM_SRC = 8;
  localparam int IDX_W = 3;
  localparam int ADDR_W = 4;
  localparam int EN_A = NUM_SRC;
  localparam int THR_A = NUM_SRC + 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NUM_SRC-1:0] srcReq;
  logic wrEn;
  logic [ADDR_W-1:0] wrAddr;
  logic [7:0] wrData;
  logic ackEn;
  logic [IDX_W-1:0] ackIdx;
  logic irqValid;
  logic [IDX_W-1:0] irqIdx;
  logic [2:0] irqLevel;

  int mLvl[NUM_SRC];
  bit mPend[NUM_SRC];
  bit mEn;
  int mThr;
  int nCmp = 0;
  int nBad = 0;
  string curReq = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  mask_irq_ctrl #(.NUM_SRC(NUM_SRC)) u_dut (
    .clk(clk), .rst_n(rst_n), .srcReq(srcReq), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .ackEn(ackEn), .ackIdx(ackIdx),
    .irqValid(irqValid), .irqIdx(irqIdx), .irqLevel(irqLevel)
  );

  task automatic modelStep();
    if (!rst_n) begin
      foreach (mLvl[i]) begin mLvl[i] = 0; mPend[i] = 0; end
      mEn = 0; mThr = 0;
    end else begin
      for (int i = 0; i < NUM_SRC; i++) begin
        if (ackEn && int'(ackIdx) == i) mPend[i] = 0;
        if (wrEn && int'(wrAddr) == i) begin
          mLvl[i] = int'(wrData[2:0]);
          if (!wrData[3]) mPend[i] = 0;
        end
        if (srcReq[i]) mPend[i] = 1;
      end
      if (wrEn && int'(wrAddr) == EN_A) mEn = wrData[0];
      if (wrEn && int'(wrAddr) == THR_A) mThr = int'(wrData[2:0]);
    end
  endtask

  task automatic compare();
    int bestIdx = -1;
    int bestLvl = 0;
    bit ok;
    for (int i = 0; i < NUM_SRC; i++)
      if (mEn && mPend[i] && mLvl[i] > mThr && mLvl[i] > bestLvl) begin
        bestIdx = i; bestLvl = mLvl[i];
      end
    nCmp++;
    if (bestIdx < 0) ok = (irqValid == 1'b0);
    else ok = irqValid && int'(irqIdx) == bestIdx && int'(irqLevel) == bestLvl;
    if (!ok) begin
      nBad++;
      $display("FAIL %s t=%0t actual valid=%0b idx=%0d lvl=%0d expected valid=%0b idx=%0d lvl=%0d",
               curReq, $time, irqValid, irqIdx, irqLevel, bestIdx >= 0, bestIdx, bestLvl);
    end
  endtask

  task automatic idle();
    srcReq = '0; wrEn = 0; wrAddr = '0; wrData = '0; ackEn = 0; ackIdx = '0;
  endtask

  task automatic tick();
    @(posedge clk);
    modelStep();
    @(negedge clk);
    compare();
    idle();
  endtask

  task automatic wr(input int a, input int d, input string req);
    curReq = req; wrEn = 1; wrAddr = ADDR_W'(a); wrData = 8'(d); tick();
  endtask

  task automatic ev(input int mask, input string req);
    curReq = req; srcReq = NUM_SRC'(mask); tick();
  endtask

  task automatic ack(input int idx, input string req);
    curReq = req; ackEn = 1; ackIdx = IDX_W'(idx); tick();
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    nBad++;
    $display("FAIL R1 watchdog expired actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

  initial begin
    idle();
    curReq = "R1";
    tick(); tick();
    rst_n = 1;
    tick(); // R1 reset state
    // R3: pending with enable off
    wr(2, 8'h0B, "R10");
    ev(32'h04, "R3");
    tick();
    wr(EN_A, 1, "R3");           // R4, R11 valid appears at once
    curReq = "R4"; tick();
    // R5 threshold
    wr(THR_A, 3, "R5");
    wr(THR_A, 2, "R5");
    wr(7, 8'h0F, "R10");
    ev(32'h80, "R5");
    wr(THR_A, 7, "R5");
    wr(THR_A, 6, "R5");
    wr(THR_A, 0, "R5");
    // R6 ranking and ties
    wr(5, 8'h0E, "R6");
    wr(1, 8'h0E, "R6");
    ev(32'h22, "R6");
    ack(7, "R7");
    ack(1, "R7");                 // R7 only source 1 drops, 5 wins
    // R8 software clear
    wr(5, 8'h0E, "R8");
    wr(5, 8'h06, "R8");
    // R9 collisions
    curReq = "R9"; srcReq = 8'h04; wrEn = 1; wrAddr = 4'd2; wrData = 8'h03; tick();
    curReq = "R9"; srcReq = 8'h04; ackEn = 1; ackIdx = 3'd2; tick();
    ack(2, "R7");
    // R2 level zero source
    ev(32'h08, "R2");
    tick();
    wr(3, 8'h0C, "R10");          // pending kept, level now 4
    wr(EN_A, 0, "R3");
    wr(EN_A, 1, "R10");
    ack(3, "R7");
    // mixed random traffic
    for (int n = 0; n < 2000; n++) begin
      curReq = "R6";
      srcReq = NUM_SRC'($urandom_range(0, 15) == 0 ? $urandom : 0);
      if ($urandom_range(0, 3) == 0) begin
        wrEn = 1;
        wrAddr = ADDR_W'($urandom_range(0, THR_A));
        wrData = 8'($urandom);
        if (wrAddr == ADDR_W'(THR_A)) wrData[2] = 1'b0;
        if (wrAddr == ADDR_W'(EN_A)) wrData[0] = ($urandom_range(0, 5) != 0);
      end
      if ($urandom_range(0, 2) == 0) begin
        ackEn = 1;
        ackIdx = irqValid ? irqIdx : IDX_W'($urandom);
      end
      tick();
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end
endmodule